// File: doc/BRIEF.md
# Bank-Selectable Debug Trace Multiplexer

This block brings internal signals of a chip out to a small group of debug pins without changing the logic being observed. The signals are grouped into equal-width banks on one wide probe input. A single selected bank is routed to the trace pins. An external controller picks the bank at run time through a serial configuration port that has its own clock. The shifted value is held back until an update strobe arrives. It then crosses into the trace clock domain and is applied in one step, so the pins never show a half-shifted selection.

In state mode the trace pins are registered and a companion pin carries the sampling clock. A two-to-one time-division option is also available in state mode. With it, every pin alternates between an even-indexed and an odd-indexed signal, so a bank is twice the pin count wide. In timing mode the pins follow the probe inputs combinationally and the clock pin stays low. The highest bank index can optionally be reserved for a built-in pseudo-random pattern. A capture instrument can use that pattern to find out how the pins are wired to its channels.

The bank count is restricted to 1, 2, 4, 8, 16, 32 or 64. The pin count is restricted to 4 to 128. Both are checked at elaboration.

Top module: `trace_bank_mux`

## Requirements
- R1: While rst_ni is low, trace_o is all zeros. Bank 0 is selected, the time-division phase is 0, the pattern generator holds 7'h7F and its delay line is zero.
- R2: Bank b occupies probe_i[b*BANK_W +: BANK_W]. In timing mode (STATE_MODE=0) trace_o[i] equals bit i of the selected bank combinationally, and trace_clk_o is held at 0.
- R3: In state mode trace_o is registered: the value after a rising clk_i edge is computed from probe_i, the selection and the phase as they stood before that edge. trace_clk_o follows clk_i.
- R4: On each rising cfg_clk_i edge with cfg_shift_i high, the serial register shifts right and cfg_data_i enters its MSB, so the first of SEL_W bits shifted ends in the LSB. A rising cfg_clk_i edge with cfg_update_i high captures the serial register. The captured value becomes the active bank on the third rising clk_i edge after that cfg_clk_i edge. Shifting without an update never changes the bank on the pins.
- R5: With time division enabled (state mode, COMPRESS=1), BANK_W is 2*PIN_W. In phase 0 pin i carries bank signal 2*i, and in phase 1 it carries signal 2*i+1. The phase inverts on every clk_i edge.
- R6: The phase returns to 0 on the clk_i edge that applies a selection update, even when the same bank is loaded again.
- R7: With TEST_BANK_EN=1, bank index NUM_BANKS-1 ignores its probe inputs. Instead it carries a PRBS-7 pattern (x^7 + x^6 + 1) seeded with all ones. On each clk_i edge the feedback bit s[6]^s[5] enters bit 0 of both the 7-bit state and a BANK_W-bit delay line. Test-bank signal k is bit k of that delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Trace clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both clock domains |
| probe_i | input | NUM_BANKS*BANK_W | All observable banks, bank b at offset b*BANK_W |
| cfg_clk_i | input | 1 | Serial configuration clock |
| cfg_shift_i | input | 1 | Shift enable for the serial select register |
| cfg_data_i | input | 1 | Serial select data |
| cfg_update_i | input | 1 | Transfer strobe for the shifted selection |
| trace_o | output | PIN_W | Debug data pins |
| trace_clk_o | output | 1 | Sampling clock pin (state mode), else 0 |

## Verification
The assertions assume three things about the inputs. Two update strobes are separated by at least two clk_i cycles, so each update yields one load pulse. The serial register does not move during the synchronizer window that follows an update. cfg_shift_i and cfg_update_i are never raised on the same cfg_clk_i edge. The bench keeps to these rules. It issues shifts and updates only through a task that pulses cfg_clk_i once per trace cycle, spends SEL_W cycles shifting before each update, and chooses at random among idle cycles, single stray shift bits and full selections, under a fixed seed.

// File: rtl/trace_mux_pkg.sv
package trace_mux_pkg;
  localparam int unsigned PRBS_W      = 7;
  localparam logic [6:0]  PRBS_SEED   = 7'h7F;
  // two metastability flops plus one edge-detect flop
  localparam int unsigned SYNC_STAGES = 3;

  function automatic int unsigned sel_width(input int unsigned nb);
    return (nb > 1) ? $clog2(nb) : 1;
  endfunction

  function automatic int unsigned bank_width(input int unsigned pw, input bit comp);
    return comp ? 2 * pw : pw;
  endfunction

  function automatic bit legal_bank_count(input int unsigned nb);
    return (nb == 1) || (nb == 2) || (nb == 4) || (nb == 8) ||
           (nb == 16) || (nb == 32) || (nb == 64);
  endfunction
endpackage

// File: rtl/trace_sel_cfg.sv
module trace_sel_cfg import trace_mux_pkg::*; #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_clk_i,
  input  logic             cfg_shift_i,
  input  logic             cfg_data_i,
  input  logic             cfg_update_i,
  output logic [SEL_W-1:0] active_sel_o,
  output logic             load_o
);
  logic [SEL_W-1:0]       shift_q, shift_nxt, hold_q, sel_q;
  logic                   flag_q;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    shift_nxt = shift_q >> 1;
    shift_nxt[SEL_W-1] = cfg_data_i;
  end

  // configuration clock domain
  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      hold_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (cfg_shift_i) shift_q <= shift_nxt;
      if (cfg_update_i) begin
        hold_q <= shift_q;
        flag_q <= ~flag_q;
      end
    end
  end

  // trace clock domain: toggle handshake, hold_q is quasi-static when sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], flag_q};
  end

  assign load_o = sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES-2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (load_o) sel_q <= hold_q;
  end

  assign active_sel_o = sel_q;
endmodule

// File: rtl/trace_prbs_gen.sv
module trace_prbs_gen import trace_mux_pkg::*; #(
  parameter int unsigned SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SEQ_W-1:0] seq_o
);
  logic [PRBS_W-1:0] lfsr_q;
  logic [SEQ_W-1:0]  seq_q;
  logic              fb;

  assign fb = lfsr_q[6] ^ lfsr_q[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= PRBS_SEED;
      seq_q  <= '0;
    end else begin
      lfsr_q <= {lfsr_q[PRBS_W-2:0], fb};
      seq_q  <= {seq_q[SEQ_W-2:0], fb};
    end
  end

  assign seq_o = seq_q;
endmodule

// File: rtl/trace_out_mux.sv
module trace_out_mux #(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned PIN_W      = 8,
  parameter int unsigned BANK_W     = 16,
  parameter int unsigned SEL_W      = 2,
  parameter bit          COMP_EN    = 1,
  parameter bit          STATE_MODE = 1,
  parameter bit          TEST_EN    = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] probe_i,
  input  logic [BANK_W-1:0]           seq_i,
  input  logic [SEL_W-1:0]            active_sel_i,
  input  logic                        load_i,
  output logic [PIN_W-1:0]            trace_o,
  output logic                        phase_o
);
  localparam logic [SEL_W-1:0] BANK_MASK = SEL_W'(NUM_BANKS - 1);
  localparam logic [SEL_W-1:0] TEST_IDX  = SEL_W'(NUM_BANKS - 1);

  logic [SEL_W-1:0]  bidx;
  logic [BANK_W-1:0] bank_vec;
  logic [PIN_W-1:0]  pin_d;
  logic              phase_q;

  assign bidx = active_sel_i & BANK_MASK;

  always_comb begin
    bank_vec = probe_i[int'(bidx) * BANK_W +: BANK_W];
    if (TEST_EN && (bidx == TEST_IDX)) bank_vec = seq_i;
  end

  generate
    if (COMP_EN) begin : g_tdm
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     phase_q <= 1'b0;
        else if (load_i) phase_q <= 1'b0;
        else             phase_q <= ~phase_q;
      end
      for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign pin_d[i] = phase_q ? bank_vec[2*i+1] : bank_vec[2*i];
      end
    end else begin : g_flat
      assign phase_q = 1'b0;
      assign pin_d   = bank_vec[PIN_W-1:0];
    end

    if (STATE_MODE) begin : g_state
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trace_o <= '0;
        else         trace_o <= pin_d;
      end
    end else begin : g_timing
      assign trace_o = pin_d;
    end
  endgenerate

  assign phase_o = phase_q;
endmodule

// File: rtl/trace_bank_mux.sv
module trace_bank_mux import trace_mux_pkg::*; #(
  parameter int unsigned NUM_BANKS    = 4,
  parameter int unsigned PIN_W        = 8,
  parameter bit          STATE_MODE   = 1,
  parameter bit          COMPRESS     = 1,
  parameter bit          TEST_BANK_EN = 1,
  localparam bit          COMP_EN = STATE_MODE && COMPRESS,
  localparam int unsigned BANK_W  = bank_width(PIN_W, COMP_EN),
  localparam int unsigned SEL_W   = sel_width(NUM_BANKS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] probe_i,
  input  logic                        cfg_clk_i,
  input  logic                        cfg_shift_i,
  input  logic                        cfg_data_i,
  input  logic                        cfg_update_i,
  output logic [PIN_W-1:0]            trace_o,
  output logic                        trace_clk_o
);
  generate
    if (!legal_bank_count(NUM_BANKS)) begin : g_bad_banks
      $error("NUM_BANKS must be 1, 2, 4, 8, 16, 32 or 64");
    end
    if (PIN_W < 4 || PIN_W > 128) begin : g_bad_pins
      $error("PIN_W must lie in 4..128");
    end
  endgenerate

  logic [SEL_W-1:0]  active_sel;
  logic              sel_load;
  logic              phase;
  logic [BANK_W-1:0] seq;

  trace_sel_cfg #(.SEL_W(SEL_W)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_clk_i    (cfg_clk_i),
    .cfg_shift_i  (cfg_shift_i),
    .cfg_data_i   (cfg_data_i),
    .cfg_update_i (cfg_update_i),
    .active_sel_o (active_sel),
    .load_o       (sel_load)
  );

  generate
    if (TEST_BANK_EN) begin : g_prbs
      trace_prbs_gen #(.SEQ_W(BANK_W)) u_prbs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .seq_o  (seq)
      );
    end else begin : g_no_prbs
      assign seq = '0;
    end
  endgenerate

  trace_out_mux #(
    .NUM_BANKS  (NUM_BANKS),
    .PIN_W      (PIN_W),
    .BANK_W     (BANK_W),
    .SEL_W      (SEL_W),
    .COMP_EN    (COMP_EN),
    .STATE_MODE (STATE_MODE),
    .TEST_EN    (TEST_BANK_EN)
  ) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .probe_i      (probe_i),
    .seq_i        (seq),
    .active_sel_i (active_sel),
    .load_i       (sel_load),
    .trace_o      (trace_o),
    .phase_o      (phase)
  );

  assign trace_clk_o = STATE_MODE ? clk_i : 1'b0;
endmodule

// File: rtl/trace_bank_mux_chk.sv
module trace_bank_mux_chk #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned BANK_W  = 16,
  parameter bit          COMP_EN = 1,
  parameter bit          TEST_EN = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_load,
  input logic [SEL_W-1:0]  active_sel,
  input logic              phase,
  input logic [BANK_W-1:0] seq
);
  AST_SEL_HELD_WITHOUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_load |=> $stable(active_sel)); // R4
  AST_LOAD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_load |=> !sel_load); // R4

  generate
    if (COMP_EN) begin : g_tdm_chk
      AST_PHASE_CLEARED_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_load |=> !phase); // R6
      AST_PHASE_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_load |=> phase != $past(phase)); // R5
    end
    if (TEST_EN) begin : g_prbs_chk
      AST_PRBS_DELAY_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> seq[BANK_W-1:1] == $past(seq[BANK_W-2:0])); // R7
    end
  endgenerate
endmodule

bind trace_bank_mux trace_bank_mux_chk #(
  .SEL_W   (SEL_W),
  .BANK_W  (BANK_W),
  .COMP_EN (COMP_EN),
  .TEST_EN (TEST_BANK_EN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_load   (sel_load),
  .active_sel (active_sel),
  .phase      (phase),
  .seq        (seq)
);

// File: tb/tb_trace_bank_mux.sv
module tb_trace_bank_mux;
  localparam int NB = 4;
  localparam int PW = 8;
  localparam int BW = 2 * PW;
  localparam int TW = PW;
  localparam int SW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_clk = 1'b0, cfg_shift = 1'b0, cfg_data = 1'b0, cfg_update = 1'b0;
  logic [NB*BW-1:0] probe = '0;
  logic [PW-1:0] trace, trace_t;
  logic tclk, tclk_t;

  always #5 clk = ~clk;

  trace_bank_mux #(.NUM_BANKS(NB), .PIN_W(PW), .STATE_MODE(1), .COMPRESS(1), .TEST_BANK_EN(1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .probe_i(probe), .cfg_clk_i(cfg_clk),
    .cfg_shift_i(cfg_shift), .cfg_data_i(cfg_data), .cfg_update_i(cfg_update),
    .trace_o(trace), .trace_clk_o(tclk));

  trace_bank_mux #(.NUM_BANKS(NB), .PIN_W(PW), .STATE_MODE(0), .COMPRESS(0), .TEST_BANK_EN(0)) dut_tm (
    .clk_i(clk), .rst_ni(rst_ni), .probe_i(probe[NB*TW-1:0]), .cfg_clk_i(cfg_clk),
    .cfg_shift_i(cfg_shift), .cfg_data_i(cfg_data), .cfg_update_i(cfg_update),
    .trace_o(trace_t), .trace_clk_o(tclk_t));

  int n_chk = 0, n_fail = 0;
  int sel_m = 0, pend_m = 0, cd = 0;
  bit ph_m = 1'b0, just_ld = 1'b0, done = 1'b0;
  logic [SW-1:0] sr_m = '0;
  logic [6:0] lfsr_m = 7'h7F;
  logic [BW-1:0] seq_m = '0;
  logic [PW-1:0] exp_q = '0;
  string exp_tag = "R1 first cycle after reset";

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] exp_main(input logic [NB*BW-1:0] pr, input int sel,
                                             input bit ph, input logic [BW-1:0] sq);
    logic [PW-1:0] v;
    for (int i = 0; i < PW; i++) begin
      int idx = 2 * i + int'(ph);
      v[i] = (sel == NB - 1) ? sq[idx] : pr[sel*BW + idx];
    end
    return v;
  endfunction

  function automatic logic [PW-1:0] exp_tm(input logic [NB*BW-1:0] pr, input int sel);
    logic [PW-1:0] v;
    for (int i = 0; i < PW; i++) v[i] = pr[sel*TW + i];
    return v;
  endfunction

  // entered at a falling clk edge, leaves at the next one
  task automatic cycle(input bit sh, input bit d, input bit up, input string tag);
    logic fb;
    check(exp_tag, trace, exp_q);
    probe = {$urandom, $urandom};
    exp_q = exp_main(probe, sel_m, ph_m, seq_m);
    if (tag != "") exp_tag = tag;
    else if (just_ld) exp_tag = "R6 phase restarts at even signals";
    else if (sel_m == NB - 1) exp_tag = "R7 test bank pattern";
    else exp_tag = ph_m ? "R5 odd phase (R3 registered)" : "R5 even phase (R3 registered)";
    just_ld = 1'b0;
    #1;
    check("R2 timing-mode pin map", trace_t, exp_tm(probe, sel_m));
    check("R2 timing-mode clock pin low", {7'b0, tclk_t}, '0);
    // model of the upcoming rising edge
    if (cd == 1) begin sel_m = pend_m; ph_m = 1'b0; just_ld = 1'b1; end
    else ph_m = ~ph_m;
    if (cd > 0) cd--;
    fb = lfsr_m[6] ^ lfsr_m[5];
    lfsr_m = {lfsr_m[5:0], fb};
    seq_m = {seq_m[BW-2:0], fb};
    // serial port
    if (sh || up) begin
      cfg_shift = sh; cfg_data = d; cfg_update = up;
      if (up) begin pend_m = int'(sr_m); cd = 2; end
      if (sh) sr_m = {d, sr_m[SW-1:1]};
      cfg_clk = 1'b1;
      #1 cfg_clk = 1'b0;
      cfg_shift = 1'b0; cfg_update = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic select_bank(input int b, input string tag);
    logic [SW-1:0] bv = SW'(b);
    for (int k = 0; k < SW; k++) cycle(1'b1, bv[k], 1'b0, "");
    cycle(1'b0, 1'b0, 1'b1, tag);
    cycle(1'b0, 1'b0, 1'b0, "R4 bank unchanged before third edge");
    cycle(1'b0, 1'b0, 1'b0, "R4 bank unchanged before third edge");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (2) @(negedge clk);
    probe = {$urandom, $urandom};
    #1;
    check("R1 reset output zero", trace, '0);
    @(posedge clk); #1;
    check("R3 clock pin high", {7'b0, tclk}, 8'd1);
    @(negedge clk); #1;
    check("R3 clock pin low", {7'b0, tclk}, 8'd0);
    check("R1 reset output zero after edges", trace, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (10) cycle(1'b0, 1'b0, 1'b0, "");
    for (int b = 0; b < NB; b++) begin
      select_bank(b, "");
      repeat (20) cycle(1'b0, 1'b0, 1'b0, "");
    end
    select_bank(1, "");
    // stray shifts with no update must not move the bank
    cycle(1'b1, 1'b0, 1'b0, "");
    cycle(1'b1, 1'b1, 1'b0, "");
    repeat (12) cycle(1'b0, 1'b0, 1'b0, "R4 shift without update ignored");
    select_bank(1, "");
    repeat (5) cycle(1'b0, 1'b0, 1'b0, "");
    select_bank(1, "");
    repeat (6) cycle(1'b0, 1'b0, 1'b0, "");
    select_bank(NB - 1, "");
    repeat (40) cycle(1'b0, 1'b0, 1'b0, "");
    repeat (400) begin
      int r = int'($urandom % 8);
      if (r == 0) select_bank(int'($urandom % NB), "");
      else if (r == 1) cycle(1'b1, 1'($urandom), 1'b0, "");
      else cycle(1'b0, 1'b0, 1'b0, "");
    end
    repeat (4) cycle(1'b0, 1'b0, 1'b0, "");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule